// File: doc/BRIEF.md
# Up/Down Pulse Counter with Limit and Threshold Events

This block is a single pulse counter. Two channels each supply an up line and a down line. Each of the four lines passes through a glitch filter that can be switched off. The rising edges of the filtered lines step a signed count. On every counted step the new count is compared against a negative low limit, a positive high limit and two free thresholds. A matching compare raises an event. When the count returns to zero, the direction it came from is recorded in a two-bit mode field.

Software reaches the block through a plain word-wide register port. A write is taken on `reg_wr_i` at the clock edge, and reads are combinational from `reg_addr_i`. The port carries configuration, pause and counter-reset control, per-event enables, a status word and a single interrupt with a write-one-to-clear. Writing a limit pair is validated: a good pair leaves the unit paused with the count cleared, and a bad pair is refused. There is no data stream in the block, so no pin uses a valid/ready handshake.

Register map (3-bit word address):
- 0: control — bit0 pause, bit1 counter reset, bit2 interrupt enable.
- 1: limits — low limit in [15:0], high limit in [31:16].
- 2: thresholds — threshold A in [15:0], threshold B in [31:16].
- 3: filter/enables — filter threshold [9:0], filter enable [10], event enables [15:11].
- 4: status (read only) — event flags [4:0], zero mode [6:5], config error [7], raw interrupt [8].
- 5: count (read only).
- 6: interrupt clear — writing 1 to bit0 clears the raw interrupt and the flags.

Event bit order, used in both the enable field and the flag field: 0 low limit, 1 high limit, 2 threshold A, 3 threshold B, 4 zero.

Top module: `pcu_unit`

## Requirements
- R1: The count is a signed 16-bit value, reads 0 after reset, and is readable at any time at address 5 in bits [15:0].
- R2: A limit write whose low half is not strictly negative or whose high half is not strictly positive is refused. The stored limits keep their old values and status bit 7 (config error) is set. A later accepted limit write clears status bit 7.
- R3: An accepted limit write stores both limits, clears the count and sets the pause bit (control bit 0).
- R4: Each rising edge of a filtered line is a request. In one cycle the up requests of both channels are counted against the down requests. More ups gives +1, more downs gives -1, and equal numbers (including an up and a down together) give no change.
- R5: While control bit 0 (pause) is set, the count does not change. While control bit 1 (counter reset) is set, the count is held at 0.
- R6: A step that lands on the high limit raises event 1, and a step that lands on the low limit raises event 0. The count stays inside the limits: a counted step taken while the count sits on either limit sets it to 0.
- R7: A step that lands on threshold A (address 2, [15:0]) raises event 2, and a step that lands on threshold B ([31:16]) raises event 3.
- R8: A step that lands on 0 raises event 4. On every counted step the zero mode (status [6:5]) is updated: 0 when the count reached zero from a positive value, 1 when it reached zero from a negative value, 2 when the new count is negative, 3 when it is positive.
- R9: An event sets its status flag and the raw interrupt only if its enable bit (address 3, bit 11 plus the event number) is set. All enables read 0 after reset.
- R10: Status bit 8 (raw interrupt) is set by any enabled event. The output `irq_o` is the raw interrupt gated by control bit 2. Writing 1 to bit0 of address 6 clears the raw interrupt and all five flags.
- R11: When the filter is enabled (address 3, bit 10), a line's new level is passed only after the line has held it for threshold+1 consecutive clocks. When the filter is disabled, the level is passed on the next clock. The filter enable and threshold read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_up_i | input | 2 | Up pulse line of each channel |
| ch_dn_i | input | 2 | Down pulse line of each channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Gated interrupt |

## Verification
The hardest situation to reach from the ports is the glitch filter running right at its threshold. The filter must reject a level held one clock too short and accept one held long enough. The bench reaches this by holding an up line for a number of clocks counted against the threshold, reading the count after each attempt, and waiting out the filter on the falling level in between. The return to zero from either limit is also hard to reach: the stimulus first narrows the limits with a valid write and then steps the count onto each limit and one step past it.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_LIMIT   = 3'd1,
    A_THRESH  = 3'd2,
    A_FILTCFG = 3'd3,
    A_STATUS  = 3'd4,
    A_COUNT   = 3'd5,
    A_IRQCLR  = 3'd6
  } addr_e;

  // bit 0 = low limit ... bit 4 = zero
  typedef struct packed {
    logic zero;
    logic thb;
    logic tha;
    logic hi;
    logic lo;
  } evt_t;

  typedef enum logic [1:0] {
    ZM_FELL = 2'd0,
    ZM_ROSE = 2'd1,
    ZM_NEG  = 2'd2,
    ZM_POS  = 2'd3
  } zmode_e;

endpackage

// File: rtl/pcu_glitch_filter.sv
module pcu_glitch_filter #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] thr,
  input  logic          raw,
  output logic          filt
);

  logic [TW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      run_q <= '0;
    end else if (!en) begin
      filt  <= raw;
      run_q <= '0;
    end else if (raw == filt) begin
      run_q <= '0;
    end else if (run_q >= thr) begin
      filt  <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/pcu_step_decode.sv
module pcu_step_decode #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] up_f,
  input  logic [NCH-1:0] dn_f,
  output logic           step_up,
  output logic           step_dn
);

  localparam int CW = $clog2(NCH + 1);

  logic [NCH-1:0] up_d, dn_d, up_rise, dn_rise;
  logic [CW-1:0]  n_up, n_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_d <= '0;
      dn_d <= '0;
    end else begin
      up_d <= up_f;
      dn_d <= dn_f;
    end
  end

  assign up_rise = up_f & ~up_d;
  assign dn_rise = dn_f & ~dn_d;

  always_comb begin
    n_up = '0;
    n_dn = '0;
    for (int i = 0; i < NCH; i++) begin
      n_up = n_up + CW'(up_rise[i]);
      n_dn = n_dn + CW'(dn_rise[i]);
    end
  end

  assign step_up = n_up > n_dn;
  assign step_dn = n_dn > n_up;

endmodule

// File: rtl/pcu_count_core.sv
module pcu_count_core
  import pcu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_up,
  input  logic                step_dn,
  input  logic                hold,
  input  logic                force_zero,
  input  logic signed [W-1:0] lim_lo,
  input  logic signed [W-1:0] lim_hi,
  input  logic signed [W-1:0] th_a,
  input  logic signed [W-1:0] th_b,
  output logic signed [W-1:0] cnt_o,
  output zmode_e              zmode_o,
  output evt_t                evt_o
);

  localparam logic signed [W-1:0] ONE = W'(1);

  logic signed [W-1:0] cnt_q, nxt;
  logic                moved;
  zmode_e              zm_q, zm_nxt;

  always_comb begin
    moved = (step_up || step_dn) && !hold && !force_zero;
    nxt   = cnt_q;
    if (force_zero)
      nxt = '0;
    else if (moved) begin
      if (cnt_q == lim_hi || cnt_q == lim_lo) nxt = '0;
      else if (step_up)                       nxt = cnt_q + ONE;
      else                                    nxt = cnt_q - ONE;
    end
  end

  always_comb begin
    if (nxt == '0)  zm_nxt = (cnt_q > 0) ? ZM_FELL : ZM_ROSE;
    else if (nxt < 0) zm_nxt = ZM_NEG;
    else            zm_nxt = ZM_POS;
  end

  always_comb begin
    evt_o.lo   = moved && (nxt == lim_lo);
    evt_o.hi   = moved && (nxt == lim_hi);
    evt_o.tha  = moved && (nxt == th_a);
    evt_o.thb  = moved && (nxt == th_b);
    evt_o.zero = moved && (nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      zm_q  <= ZM_FELL;
    end else begin
      cnt_q <= nxt;
      if (moved) zm_q <= zm_nxt;
    end
  end

  assign cnt_o   = cnt_q;
  assign zmode_o = zm_q;

endmodule

// File: rtl/pcu_unit.sv
module pcu_unit
  import pcu_pkg::*;
#(
  parameter int W   = 16,
  parameter int TW  = 10,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_up_i,
  input  logic [NCH-1:0] ch_dn_i,
  input  logic           reg_wr_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [2*W-1:0] reg_wdata_i,
  output logic [2*W-1:0] reg_rdata_o,
  output logic           irq_o
);

  localparam int DW  = 2 * W;
  localparam int NEV = $bits(evt_t);
  localparam int EVB = TW + 1;

  // configuration and control state
  logic                pause_q, cnt_rst_q, irq_en_q;
  logic signed [W-1:0] lim_lo_q, lim_hi_q, th_a_q, th_b_q;
  logic                filt_en_q;
  logic [TW-1:0]       filt_thr_q;
  evt_t                evt_en_q, flags_q;
  logic                irq_raw_q, cfg_err_q;

  // write decode
  logic                wr_ctrl, wr_lim, wr_th, wr_fc, wr_clr;
  logic signed [W-1:0] new_lo, new_hi;
  logic                lim_wr_ok, lim_wr_bad, irq_clr;

  assign wr_ctrl    = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_lim     = reg_wr_i && (reg_addr_i == A_LIMIT);
  assign wr_th      = reg_wr_i && (reg_addr_i == A_THRESH);
  assign wr_fc      = reg_wr_i && (reg_addr_i == A_FILTCFG);
  assign wr_clr     = reg_wr_i && (reg_addr_i == A_IRQCLR);
  assign new_lo     = reg_wdata_i[W-1:0];
  assign new_hi     = reg_wdata_i[DW-1:W];
  assign lim_wr_ok  = wr_lim && (new_lo < 0) && (new_hi > 0);
  assign lim_wr_bad = wr_lim && !lim_wr_ok;
  assign irq_clr    = wr_clr && reg_wdata_i[0];

  // filters, one per line
  logic [NCH-1:0] up_f, dn_f;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcu_glitch_filter #(.TW(TW)) u_fup (
      .clk(clk), .rst_n(rst_n), .en(filt_en_q), .thr(filt_thr_q),
      .raw(ch_up_i[c]), .filt(up_f[c])
    );
    pcu_glitch_filter #(.TW(TW)) u_fdn (
      .clk(clk), .rst_n(rst_n), .en(filt_en_q), .thr(filt_thr_q),
      .raw(ch_dn_i[c]), .filt(dn_f[c])
    );
  end

  logic step_up, step_dn;

  pcu_step_decode #(.NCH(NCH)) u_step (
    .clk(clk), .rst_n(rst_n), .up_f(up_f), .dn_f(dn_f),
    .step_up(step_up), .step_dn(step_dn)
  );

  logic signed [W-1:0] cnt;
  zmode_e              zmode;
  evt_t                evt, evt_gated;
  logic                evt_any;

  pcu_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .hold(pause_q), .force_zero(cnt_rst_q || lim_wr_ok),
    .lim_lo(lim_lo_q), .lim_hi(lim_hi_q), .th_a(th_a_q), .th_b(th_b_q),
    .cnt_o(cnt), .zmode_o(zmode), .evt_o(evt)
  );

  assign evt_gated = evt & evt_en_q;
  assign evt_any   = |evt_gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_q    <= 1'b0;
      cnt_rst_q  <= 1'b0;
      irq_en_q   <= 1'b0;
      lim_lo_q   <= {1'b1, {(W-1){1'b0}}};
      lim_hi_q   <= {1'b0, {(W-1){1'b1}}};
      th_a_q     <= '0;
      th_b_q     <= '0;
      filt_en_q  <= 1'b0;
      filt_thr_q <= '0;
      evt_en_q   <= '0;
      cfg_err_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pause_q   <= reg_wdata_i[0];
        cnt_rst_q <= reg_wdata_i[1];
        irq_en_q  <= reg_wdata_i[2];
      end else if (lim_wr_ok) begin
        pause_q <= 1'b1;
      end
      if (lim_wr_ok) begin
        lim_lo_q  <= new_lo;
        lim_hi_q  <= new_hi;
        cfg_err_q <= 1'b0;
      end else if (lim_wr_bad) begin
        cfg_err_q <= 1'b1;
      end
      if (wr_th) begin
        th_a_q <= reg_wdata_i[W-1:0];
        th_b_q <= reg_wdata_i[DW-1:W];
      end
      if (wr_fc) begin
        filt_thr_q <= reg_wdata_i[TW-1:0];
        filt_en_q  <= reg_wdata_i[TW];
        evt_en_q   <= reg_wdata_i[EVB+NEV-1:EVB];
      end
    end
  end

  // latched flags and raw interrupt: a new event wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      irq_raw_q <= 1'b0;
    end else begin
      flags_q   <= (irq_clr ? evt_t'('0) : flags_q) | evt_gated;
      irq_raw_q <= (irq_clr ? 1'b0 : irq_raw_q) | evt_any;
    end
  end

  assign irq_o = irq_raw_q && irq_en_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:    reg_rdata_o[2:0] = {irq_en_q, cnt_rst_q, pause_q};
      A_LIMIT:   reg_rdata_o = {lim_hi_q, lim_lo_q};
      A_THRESH:  reg_rdata_o = {th_b_q, th_a_q};
      A_FILTCFG: reg_rdata_o[EVB+NEV-1:0] = {evt_en_q, filt_en_q, filt_thr_q};
      A_STATUS:  reg_rdata_o[NEV+3:0] = {irq_raw_q, cfg_err_q, zmode, flags_q};
      A_COUNT:   reg_rdata_o[W-1:0] = cnt;
      default:   reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pcu_unit_chk.sv
module pcu_unit_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic signed [W-1:0] cnt,
  input logic signed [W-1:0] lim_lo,
  input logic signed [W-1:0] lim_hi,
  input logic                pause,
  input logic                cnt_rst,
  input logic                cfg_err,
  input logic                lim_wr_ok,
  input logic                lim_wr_bad,
  input logic                irq_clr,
  input logic                evt_any,
  input logic                irq
);

  localparam logic signed [W-1:0] ONE = W'(1);

  AST_CNT_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= lim_lo) && (cnt <= lim_hi)); // R6

  AST_BAD_LIMIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr_bad |=> cfg_err && $stable(lim_lo) && $stable(lim_hi)); // R2

  AST_CFG_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr_ok |=> pause && (cnt == '0)); // R3

  AST_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (cnt == '0)); // R5

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !cnt_rst && !lim_wr_ok) |=> $stable(cnt)); // R5

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_rst && !lim_wr_ok) |=> ((cnt == '0) || (cnt == $past(cnt)) ||
      (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE))); // R4

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !evt_any) |=> !irq); // R10

endmodule

bind pcu_unit pcu_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .lim_lo(lim_lo_q), .lim_hi(lim_hi_q),
  .pause(pause_q), .cnt_rst(cnt_rst_q), .cfg_err(cfg_err_q),
  .lim_wr_ok(lim_wr_ok), .lim_wr_bad(lim_wr_bad), .irq_clr(irq_clr),
  .evt_any(evt_any), .irq(irq_o)
);

// File: tb/test_pcu_unit.sv
module test_pcu_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // table: up mask, down mask, expected count after the step
  localparam int VUP[NV]  = '{1, 3, 1, 0, 3, 0, 0, 0, 1};
  localparam int VDN[NV]  = '{0, 0, 1, 2, 1, 3, 1, 1, 0};
  localparam int VEXP[NV] = '{1, 2, 2, 1, 2, 1, 0, -1, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ch_up = '0, ch_dn = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcu_unit i_pcu_unit (
    .clk(clk), .rst_n(rst_n), .ch_up_i(ch_up), .ch_dn_i(ch_dn),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int cnt_of(input logic [31:0] d);
    return int'($signed(d[15:0]));
  endfunction

  task automatic pulse(input logic [1:0] up, input logic [1:0] dn);
    @(negedge clk);
    ch_up = up; ch_dn = dn;
    @(negedge clk);
    ch_up = '0; ch_dn = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic hold_up(input int len);
    @(negedge clk);
    ch_up = 2'b01;
    repeat (len) @(negedge clk);
    ch_up = '0;
    repeat (10) @(negedge clk);
  endtask

  task automatic ups(input int n);
    for (int i = 0; i < n; i++) pulse(2'b01, 2'b00);
  endtask

  task automatic downs(input int n);
    for (int i = 0; i < n; i++) pulse(2'b00, 2'b01);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd5, rv); chk("R1 reset count", cnt_of(rv), 0);
    rd(3'd4, rv); chk("R9 reset status", int'(rv[8:0]), 0);
    rd(3'd3, rv); chk("R9 R11 reset enables and filter", int'(rv[15:0]), 0);
    rd(3'd0, rv); chk("R5 reset control", int'(rv[2:0]), 0);
    chk("R10 reset irq", int'(irq), 0);

    // accepted limits leave unit paused
    wr(3'd1, {16'd5, 16'hFFFB});
    rd(3'd0, rv); chk("R3 paused after limit write", int'(rv[0]), 1);
    pulse(2'b01, 2'b00);
    rd(3'd5, rv); chk("R5 pause freezes count", cnt_of(rv), 0);
    wr(3'd0, 32'd0);

    // table of steps for R4 / R1
    for (int v = 0; v < NV; v++) begin
      pulse(VUP[v][1:0], VDN[v][1:0]);
      rd(3'd5, rv);
      chk($sformatf("R4 R1 vector %0d", v), cnt_of(rv), VEXP[v]);
    end

    // refused limit writes
    wr(3'd1, {16'd5, 16'd3});
    rd(3'd4, rv); chk("R2 config error on nonnegative low", int'(rv[7]), 1);
    rd(3'd1, rv); chk("R2 limits kept", int'(rv), int'({16'd5, 16'hFFFB}));
    wr(3'd1, {16'd0, 16'hFFFB});
    rd(3'd1, rv); chk("R2 limits kept on zero high", int'(rv), int'({16'd5, 16'hFFFB}));

    // counter reset
    ups(2);
    rd(3'd5, rv); chk("R4 two ups", cnt_of(rv), 2);
    wr(3'd0, 32'd2);
    rd(3'd5, rv); chk("R5 reset clears count", cnt_of(rv), 0);
    ups(1);
    rd(3'd5, rv); chk("R5 reset holds count", cnt_of(rv), 0);
    wr(3'd0, 32'd0);
    ups(1);
    rd(3'd5, rv); chk("R5 count after reset released", cnt_of(rv), 1);

    // new limits: count cleared, error cleared
    wr(3'd1, {16'd3, 16'hFFFD});
    rd(3'd5, rv); chk("R3 count cleared by limit write", cnt_of(rv), 0);
    rd(3'd4, rv); chk("R2 config error cleared", int'(rv[7]), 0);
    wr(3'd3, 32'h1F << 11);
    wr(3'd0, 32'd4);

    // high limit and wrap
    ups(3);
    rd(3'd5, rv); chk("R6 count at high limit", cnt_of(rv), 3);
    rd(3'd4, rv); chk("R6 high limit flag", int'(rv[1]), 1);
    chk("R10 irq asserted", int'(irq), 1);
    wr(3'd6, 32'd1);
    rd(3'd4, rv); chk("R10 clear flags and raw", int'({rv[8], rv[4:0]}), 0);
    chk("R10 irq cleared", int'(irq), 0);
    ups(1);
    rd(3'd5, rv); chk("R6 wrap from high limit", cnt_of(rv), 0);
    rd(3'd4, rv);
    chk("R8 zero flag", int'(rv[4]), 1);
    chk("R8 mode fell to zero", int'(rv[6:5]), 0);
    wr(3'd6, 32'd1);

    // low limit and wrap
    downs(1);
    rd(3'd4, rv); chk("R8 mode negative", int'(rv[6:5]), 2);
    downs(2);
    rd(3'd5, rv); chk("R6 count at low limit", cnt_of(rv), -3);
    rd(3'd4, rv); chk("R6 low limit flag", int'(rv[0]), 1);
    downs(1);
    rd(3'd5, rv); chk("R6 wrap from low limit", cnt_of(rv), 0);
    rd(3'd4, rv); chk("R8 mode rose to zero", int'(rv[6:5]), 1);
    wr(3'd6, 32'd1);

    // thresholds
    wr(3'd2, {16'hFFFE, 16'd2});
    ups(2);
    rd(3'd4, rv);
    chk("R7 threshold A flag", int'(rv[2]), 1);
    chk("R8 mode positive", int'(rv[6:5]), 3);
    wr(3'd6, 32'd1);
    downs(4);
    rd(3'd4, rv); chk("R7 threshold B flag", int'(rv[3]), 1);
    wr(3'd6, 32'd1);
    ups(2);
    wr(3'd6, 32'd1);

    // enables off: no flags
    wr(3'd3, 32'd0);
    ups(2);
    rd(3'd4, rv); chk("R9 disabled event not latched", int'({rv[8], rv[4:0]}), 0);
    downs(2);

    // interrupt gating
    wr(3'd3, 32'h1F << 11);
    wr(3'd0, 32'd0);
    ups(2);
    rd(3'd4, rv); chk("R10 raw set with irq disabled", int'(rv[8]), 1);
    chk("R10 irq gated off", int'(irq), 0);
    wr(3'd0, 32'd4);
    @(negedge clk); chk("R10 irq after enable", int'(irq), 1);
    downs(2);
    wr(3'd6, 32'd1);
    rd(3'd5, rv); chk("R1 count back at zero", cnt_of(rv), 0);

    // glitch filter, threshold 3
    wr(3'd3, 32'd3 | (32'd1 << 10));
    hold_up(3);
    rd(3'd5, rv); chk("R11 short level rejected", cnt_of(rv), 0);
    hold_up(5);
    rd(3'd5, rv); chk("R11 long level accepted", cnt_of(rv), 1);

    summary();
  end

endmodule